// File: doc/BRIEF.md
# Brent-Kung Prefix Adder

A purely combinational adder of parameterized width (16 bits by default) that sums two operands and a carry input. It returns a sum of the same width and a carry output. The work is split into three stages. The first stage forms a propagate bit (exclusive OR of the operand bits) and a generate bit (AND of the operand bits) for every position. It folds the carry input into the generate of bit 0, so from that point on the carry into position i+1 equals the group generate of bits i down to 0.

The middle stage is a Brent-Kung prefix network built from a single span-merge cell. The cell takes a more significant span (Pa, Ga) and the adjacent less significant span (Pb, Gb) and returns P = Pa·Pb and G = Ga + Pa·Gb. Because this merge is associative and idempotent, spans can be built in any grouping.

A forward tree with pairing factor two builds the power-of-two spans that end at bits 1, 3, 7 and 15. These give the carries into bits 2, 4, 8 and 16. Back-propagation subtrees then fill in the remaining carries from spans that already exist. With width W the network has 2·log2(W) − 1 merge levels, which is 7 at the default width. The last stage forms each sum bit as the exclusive OR of that bit's propagate and its incoming carry. The width must be a power of two, and this is checked at elaboration.

Top module: `bk_adder`

## Requirements
- R1: For any operands, the (W+1)-bit value {cout_o, sum_o} equals x_i + y_i + cin_i.
- R2: When every bit propagates (x_i XOR y_i all ones), the carry input crosses the full width: cin_i=1 gives sum_o=0 and cout_o=1, and cin_i=0 gives sum_o all ones and cout_o=0.
- R3: All-ones plus one with cin_i=0 gives sum_o=0 and cout_o=1.
- R4: Zero plus zero gives sum_o=0 and cout_o=0 with cin_i=0, and gives sum_o=1 and cout_o=0 with cin_i=1.
- R5: A carry generated only at the top bit (x_i = y_i = 2^(W−1)) appears on cout_o=1 with sum_o=0.
- R6: A carry generated at bit k (x_i = y_i = 2^k, k < W−1) stops at bit k+1, where both operands are zero: sum_o = 2^(k+1) and cout_o=0.
- R7: A run of k low ones plus one (x_i = 2^k − 1, y_i = 1) yields sum_o = 2^k for every k in 1..W−1, covering the carries that come from the back-propagation subtrees. With k = W, the result is sum_o=0 and cout_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | W | First operand |
| y_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Sum bits |
| cout_o | output | 1 | Carry out of bit W−1 |

## Verification
Two carry sources can target the same stretch of bits in one evaluation: the carry input folded into bit 0, and a generate produced inside the operands. The bench provokes this by pairing patterns that generate a carry with cin_i=1, such as alternating operands, all-ones operands and random operands with the carry input set. It judges the result against a behavioural W+1-bit sum, so a carry that is dropped or counted twice at a span boundary shows up as a wrong sum bit or carry output.

// File: rtl/bk_pkg.sv
package bk_pkg;

   // true when n is a power of two not below 2
   function automatic bit bk_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   // merge levels of the Brent-Kung network for width n
   function automatic int bk_levels(input int n);
      return 2 * $clog2(n) - 1;
   endfunction

endpackage

// File: rtl/bk_pg_stage.sv
module bk_pg_stage #(
   parameter int W = 16
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] p_o,
   output logic [W-1:0] g_o
);

   always_comb begin
      p_o    = x_i ^ y_i;
      g_o    = x_i & y_i;
      g_o[0] = (x_i[0] & y_i[0]) | ((x_i[0] ^ y_i[0]) & cin_i);
   end

   // R1: above bit 0 a position never both propagates and generates
   always_comb begin
      for (int m = 1; m < W; m++) begin
         pg_excl_chk: assert (!(p_o[m] && g_o[m]))
            else $error("bit %0d both propagates and generates", m);
      end
   end

endmodule

// File: rtl/bk_carry_op.sv
module bk_carry_op (
   input  logic p_hi_i,
   input  logic g_hi_i,
   input  logic p_lo_i,
   input  logic g_lo_i,
   output logic p_o,
   output logic g_o
);

   assign p_o = p_hi_i & p_lo_i;
   assign g_o = g_hi_i | (p_hi_i & g_lo_i);

   // R1: a span that only passes a carry hands on the lower span's generate
   always_comb begin
      if (p_hi_i && !g_hi_i) begin
         span_pass_chk: assert (g_o == g_lo_i)
            else $error("merged generate differs from lower span");
      end
   end

endmodule

// File: rtl/bk_prefix_tree.sv
module bk_prefix_tree
   import bk_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] p_i,
   input  logic [W-1:0] g_i,
   output logic [W-1:0] c_o
);

   localparam int LV = $clog2(W);
   localparam int ST = bk_levels(W);

   wire [W-1:0] pw [0:ST];
   wire [W-1:0] gw [0:ST];

   assign pw[0] = p_i;
   assign gw[0] = g_i;

   // forward reduction: pairing factor two
   for (genvar lv = 1; lv <= LV; lv++) begin : g_fwd
      localparam int SP = 1 << lv;
      localparam int HF = 1 << (lv - 1);
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (((i + 1) % SP) == 0) begin : g_op
            bk_carry_op u_op (
               .p_hi_i (pw[lv-1][i]),
               .g_hi_i (gw[lv-1][i]),
               .p_lo_i (pw[lv-1][i-HF]),
               .g_lo_i (gw[lv-1][i-HF]),
               .p_o    (pw[lv][i]),
               .g_o    (gw[lv][i])
            );
         end else begin : g_pass
            assign pw[lv][i] = pw[lv-1][i];
            assign gw[lv][i] = gw[lv-1][i];
         end
      end
   end

   // back-propagation subtrees fill the remaining prefixes
   for (genvar bl = 1; bl < LV; bl++) begin : g_bwd
      localparam int STG = LV + bl;
      localparam int SP  = 1 << (LV - bl);
      localparam int HF  = SP / 2;
      for (genvar i = 0; i < W; i++) begin : g_bit
         if ((((i + 1) % SP) == HF) && (i >= SP)) begin : g_op
            bk_carry_op u_op (
               .p_hi_i (pw[STG-1][i]),
               .g_hi_i (gw[STG-1][i]),
               .p_lo_i (pw[STG-1][i-HF]),
               .g_lo_i (gw[STG-1][i-HF]),
               .p_o    (pw[STG][i]),
               .g_o    (gw[STG][i])
            );
         end else begin : g_pass
            assign pw[STG][i] = pw[STG-1][i];
            assign gw[STG][i] = gw[STG-1][i];
         end
      end
   end

   assign c_o = gw[ST];

   // R2: with every upper bit propagating, the top carry is bit 0's generate
   always_comb begin
      if (&p_i[W-1:1]) begin
         full_prop_chk: assert (c_o[W-1] == g_i[0])
            else $error("carry did not cross a fully propagating word");
      end
   end

endmodule

// File: rtl/bk_sum_stage.sv
module bk_sum_stage #(
   parameter int W = 16
) (
   input  logic [W-1:0] p_i,
   input  logic [W-1:0] cy_i,
   output logic [W-1:0] s_o
);

   for (genvar m = 0; m < W; m++) begin : g_sum
      assign s_o[m] = p_i[m] ^ cy_i[m];
   end

endmodule

// File: rtl/bk_adder.sv
module bk_adder
   import bk_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);

   if (!bk_pow2(W)) begin : g_bad_width
      $error("bk_adder: W=%0d must be a power of two not below 2", W);
   end

   logic [W-1:0] prop, gen, pref, cin_vec;

   bk_pg_stage #(.W(W)) u_pg (
      .x_i   (x_i),
      .y_i   (y_i),
      .cin_i (cin_i),
      .p_o   (prop),
      .g_o   (gen)
   );

   bk_prefix_tree #(.W(W)) u_tree (
      .p_i (prop),
      .g_i (gen),
      .c_o (pref)
   );

   assign cin_vec = {pref[W-2:0], cin_i};
   assign cout_o  = pref[W-1];

   bk_sum_stage #(.W(W)) u_sum (
      .p_i  (prop),
      .cy_i (cin_vec),
      .s_o  (sum_o)
   );

   // R1
   always_comb begin
      sum_total_chk: assert ({cout_o, sum_o} ==
                             ((W+1)'(x_i) + (W+1)'(y_i) + (W+1)'(cin_i)))
         else $error("sum mismatch");
   end

endmodule

// File: tb/bk_adder_tb.sv
module bk_adder_tb;

   localparam int W          = 16;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic [W-1:0] x_i = '0;
   logic [W-1:0] y_i = '0;
   logic         cin_i = 1'b0;
   logic [W-1:0] sum_o;
   logic         cout_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bk_adder #(.W(W)) u_dut (
      .x_i    (x_i),
      .y_i    (y_i),
      .cin_i  (cin_i),
      .sum_o  (sum_o),
      .cout_o (cout_o)
   );

   // drive on the falling edge, sample just after the rising edge
   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c);
      @(negedge clk);
      x_i   = a;
      y_i   = b;
      cin_i = c;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_val(input string req, input logic [W-1:0] es,
                             input logic ec);
      n_chk++;
      if (sum_o !== es || cout_o !== ec) begin
         n_fail++;
         $display("FAIL %s: x=%h y=%h cin=%b got s=%h c=%b expected s=%h c=%b",
                  req, x_i, y_i, cin_i, sum_o, cout_o, es, ec);
      end
   endtask

   // behavioural reference: plain integer addition
   task automatic ref_check(input string req, input logic [W-1:0] a,
                            input logic [W-1:0] b, input logic c);
      longint tot;
      apply(a, b, c);
      tot = longint'(a) + longint'(b) + longint'(c);
      expect_val(req, tot[W-1:0], tot[W]);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] ones;
      ones = '1;

      // R4: quiet start and zero operands
      apply('0, '0, 1'b0);
      expect_val("R4", '0, 1'b0);
      apply('0, '0, 1'b1);
      expect_val("R4", W'(1), 1'b0);

      // R3
      apply(ones, W'(1), 1'b0);
      expect_val("R3", '0, 1'b1);

      // R2: full propagate chains
      apply(16'hAAAA, 16'h5555, 1'b1);
      expect_val("R2", '0, 1'b1);
      apply(16'hAAAA, 16'h5555, 1'b0);
      expect_val("R2", ones, 1'b0);
      apply(ones, '0, 1'b1);
      expect_val("R2", '0, 1'b1);

      // R5
      apply(W'(1) << (W-1), W'(1) << (W-1), 1'b0);
      expect_val("R5", '0, 1'b1);

      // R6: generate at bit k, killed at bit k+1
      for (int k = 0; k < W-1; k++) begin
         apply(W'(1) << k, W'(1) << k, 1'b0);
         expect_val("R6", W'(1) << (k+1), 1'b0);
      end

      // R7: low runs of ones plus one
      for (int k = 1; k < W; k++) begin
         apply((W'(1) << k) - W'(1), W'(1), 1'b0);
         expect_val("R7", W'(1) << k, 1'b0);
      end
      apply(ones, W'(1), 1'b0);
      expect_val("R7", '0, 1'b1);

      // R1: alternating, corner and random operands, both carry-in values
      ref_check("R1", 16'hAAAA, 16'hAAAA, 1'b1);
      ref_check("R1", 16'h5555, 16'h5555, 1'b1);
      ref_check("R1", ones, ones, 1'b1);
      ref_check("R1", ones, ones, 1'b0);
      ref_check("R1", 16'h00FF, 16'h0F0F, 1'b1);
      for (int n = 0; n < 3000; n++) begin
         ref_check("R1", W'($urandom), W'($urandom), 1'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_fail);
      $finish;
   end

endmodule